// File: doc/BRIEF.md
# Page Table Entry Cache

This block sits between an address-translation walker and memory. The walker issues one 32-bit word read at a time, giving a physical address of up to 34 bits. A direct-mapped store of atom-sized lines answers hits one cycle after the request is accepted. On a miss, the block fetches the whole atom from memory as a run of single-word requests in ascending order. It returns the requested word once the last beat is in, and marks the line valid.

Software has three write strobes. The first loads a configuration word holding a global enable, a cap on outstanding memory reads and a mask that chooses which line-address bits index the store. The second loads a 2-bit upper-address register. The third issues a flush command that drops either every line or the single line covering a given physical address. When the cache is disabled, each walker read becomes one uncached memory read, and nothing is allocated.

Top module: `pte_cache`

## Requirements
- R1: After reset, rd_ready is 1, rsp_valid and mem_req_valid are 0, and the configuration is enabled with index mask 0x3f and request cap 8.
- R2: A read that misses fetches the ATOM_BYTES/4 words of its atom in ascending address order, starting at the atom-aligned base. rsp_valid rises one cycle after the last memory beat is taken, and rsp_data carries the requested word.
- R3: A read that hits raises rsp_valid in the cycle after acceptance, returns the cached word, and issues no memory request.
- R4: Line tags cover the whole ADDR_W-bit address, so two addresses that differ only in bits 33:32 never hit on each other.
- R5: A flush command with bit 0 equal to 0 invalidates every line.
- R6: A flush command with bit 0 equal to 1 invalidates only the line holding the flush address, after its low bits are rounded down to the atom boundary. Other lines keep hitting.
- R7: For an address flush, bits 33:32 of the flush address come from the 2-bit upper-address register, which is written beforehand.
- R8: In the configuration word, bit 29 is the enable, bits 27:24 are the request cap and bits 5:0 are the index mask. While disabled, every read issues exactly one memory read of its word-aligned address and allocates no line.
- R9: The number of memory reads issued and not yet answered never exceeds the request cap. A cap of 0 means 16.
- R10: The store index of a line is the low log2(LINES) bits of its line address ANDed with the index mask, so a mask of 0 makes all lines collide.
- R11: A flush that arrives while a line fill is in progress still lets the walker's word be returned, but leaves that line invalid.
- R12: rd_ready is 0 from the acceptance of a missing or uncached read until its response is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Walker read request |
| rd_ready | output | 1 | Block can accept a walker read |
| rd_addr | input | ADDR_W | Physical byte address of the word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Returned word |
| mem_req_valid | output | 1 | Memory word-read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word-aligned memory address |
| mem_rsp_valid | input | 1 | Memory returns a word (in request order) |
| mem_rsp_data | input | 32 | Memory word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| flush_hi_we | input | 1 | Upper flush address write strobe |
| flush_hi_wdata | input | 2 | Flush address bits 33:32 |
| flush_we | input | 1 | Flush command strobe |
| flush_wdata | input | 32 | Flush type (bit 0) and address bits 31:0 |

## Verification
A hit is due at the first falling edge after the accepting rising edge. A miss or uncached read is due exactly one cycle after the memory model hands over its final beat. The bench records the cycle of every beat and compares it with the cycle in which rsp_valid is seen. Configuration and flush writes take effect at the next rising edge, so the reads that follow them are issued only after that edge. The behavioural model of line validity, tags and the outstanding-request count is compared with the design's responses and memory traffic on every read and every clock.

// File: rtl/pte_cache_pkg.sv
// Shared types and helpers for the page table entry cache.
package pte_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_BYP  = 2'd2
    } pc_state_e;

    // Field positions inside the configuration word
    localparam int CFG_EN_BIT  = 29;
    localparam int CFG_LIM_LSB = 24;
    localparam int CFG_MAP_W   = 6;

    // A request cap of zero stands for sixteen
    function automatic logic [4:0] eff_limit(input logic [3:0] cap);
        return (cap == 4'd0) ? 5'd16 : {1'b0, cap};
    endfunction

endpackage

// File: rtl/pte_cache_regs.sv
// Configuration, upper flush address and flush-command decode.
// Assumes: ADDR_W between 32 and 34; flush strobes act in the cycle they are high.
module pte_cache_regs #(
    parameter int ADDR_W = 34,
    parameter int OFS_W  = 5,
    localparam int LA_W  = ADDR_W - OFS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [31:0]     cfg_wdata,
    input  logic            hi_we,
    input  logic [1:0]      hi_wdata,
    input  logic            flush_we,
    input  logic [31:0]     flush_wdata,
    output logic            cache_en,
    output logic [3:0]      req_limit,
    output logic [5:0]      idx_map,
    output logic            inv_all,
    output logic            inv_one,
    output logic [LA_W-1:0] inv_line
);
    import pte_cache_pkg::*;

    logic [1:0] hi_q;
    logic       unused_cfg;

    // Hold configuration and upper flush address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_en  <= 1'b1;
            req_limit <= 4'd8;
            idx_map   <= 6'h3f;
            hi_q      <= 2'b00;
        end else begin
            if (cfg_we) begin
                cache_en  <= cfg_wdata[CFG_EN_BIT];
                req_limit <= cfg_wdata[CFG_LIM_LSB +: 4];
                idx_map   <= cfg_wdata[CFG_MAP_W-1:0];
            end
            if (hi_we)
                hi_q <= hi_wdata;
        end
    end

    // Decode flush type from bit 0
    assign inv_all = flush_we & ~flush_wdata[0];
    assign inv_one = flush_we &  flush_wdata[0];

    // Build the atom-aligned flush line address for the configured width
    generate
        if (ADDR_W > 32) begin : g_wide
            assign inv_line = {hi_q[ADDR_W-33:0], flush_wdata[31:OFS_W]};
        end else begin : g_narrow
            assign inv_line = flush_wdata[ADDR_W-1:OFS_W];
        end
    endgenerate

    assign unused_cfg = ^{cfg_wdata[31:30], cfg_wdata[23:6], flush_wdata[OFS_W-1:1], hi_q};

endmodule

// File: rtl/pte_cache_store.sv
// Direct-mapped line store: valid bits, full line-address tags and word data.
// Assumes: LINES and WORDS are powers of two; invalidation wins over allocation.
module pte_cache_store #(
    parameter int LINES  = 8,
    parameter int WORDS  = 8,
    parameter int LA_W   = 29,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [LA_W-1:0]   lk_line,
    input  logic [WIDX_W-1:0] lk_word,
    output logic              lk_hit,
    output logic [31:0]       lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [31:0]       wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [LA_W-1:0]   set_line,
    input  logic              inv_all,
    input  logic              inv_one,
    input  logic [LA_W-1:0]   inv_line,
    output logic [LINES-1:0]  line_vld
);
    logic [31:0]     data_q [LINES*WORDS];
    logic [LA_W-1:0] tag_q  [LINES];
    logic [LINES-1:0] vld_q;

    // Maintain valid bits: flushes and victim clears beat allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int g = 0; g < LINES; g++) begin
                if (inv_all || (inv_one && tag_q[g] == inv_line) ||
                    (clr_en && clr_idx == IDX_W'(g)))
                    vld_q[g] <= 1'b0;
                else if (set_en && set_idx == IDX_W'(g))
                    vld_q[g] <= 1'b1;
            end
        end
    end

    // Record the line address of each allocated line
    always_ff @(posedge clk) begin
        for (int g = 0; g < LINES; g++)
            if (set_en && set_idx == IDX_W'(g))
                tag_q[g] <= set_line;
    end

    // Write fill beats into the data array
    always_ff @(posedge clk) begin
        if (wr_en)
            data_q[{wr_idx, wr_word}] <= wr_data;
    end

    assign lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_line);
    assign lk_data  = data_q[{lk_idx, lk_word}];
    assign line_vld = vld_q;

endmodule

// File: rtl/pte_cache_ostd.sv
// Tracks memory reads in flight and gates new issues against the cap.
// Assumes: memory answers every accepted read exactly once.
module pte_cache_ostd (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] req_limit,
    input  logic       issue,
    input  logic       retire,
    output logic       can_issue
);
    import pte_cache_pkg::*;

    logic [4:0] cnt_q;

    // Count issued minus returned reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (issue && !retire)
            cnt_q <= cnt_q + 5'd1;
        else if (!issue && retire)
            cnt_q <= cnt_q - 5'd1;
    end

    assign can_issue = cnt_q < eff_limit(req_limit);

endmodule

// File: rtl/pte_cache.sv
// Page table entry cache top: serves walker word reads from a direct-mapped
// line store, fills whole atoms from memory, or bypasses when disabled.
// Assumes: one walker read at a time; memory returns words in request order.
module pte_cache #(
    parameter int ADDR_W     = 34,
    parameter int ATOM_BYTES = 32,
    parameter int LINES      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              flush_hi_we,
    input  logic [1:0]        flush_hi_wdata,
    input  logic              flush_we,
    input  logic [31:0]       flush_wdata
);
    import pte_cache_pkg::*;

    localparam int OFS_W  = $clog2(ATOM_BYTES);
    localparam int WORDS  = ATOM_BYTES / 4;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int CNT_W  = WIDX_W + 1;
    localparam int LA_W   = ADDR_W - OFS_W;
    localparam int IDX_W  = $clog2(LINES);

    pc_state_e         state;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  n_iss, n_rx;
    logic              killed;
    logic [31:0]       pend_q;

    logic              cache_en, inv_all, inv_one, can_issue, lk_hit;
    logic [3:0]        req_limit;
    logic [5:0]        idx_map;
    logic [LA_W-1:0]   inv_line, lk_line, cur_line;
    logic [IDX_W-1:0]  lk_idx, cur_idx;
    logic [WIDX_W-1:0] cur_word;
    logic [31:0]       lk_data;
    logic [LINES-1:0]  line_vld;
    logic              accept, issue, wr_en, last_beat, set_en, clr_en;
    logic              unused_bits;

    // Mask the low line-address bits with the configured index map
    function automatic logic [IDX_W-1:0] idx_of(input logic [LA_W-1:0] line,
                                                input logic [5:0] map);
        return line[IDX_W-1:0] & map[IDX_W-1:0];
    endfunction

    assign lk_line  = rd_addr[ADDR_W-1:OFS_W];
    assign lk_idx   = idx_of(lk_line, idx_map);
    assign cur_line = cur_addr[ADDR_W-1:OFS_W];
    assign cur_idx  = idx_of(cur_line, idx_map);
    assign cur_word = cur_addr[OFS_W-1:2];

    assign rd_ready      = (state == ST_IDLE);
    assign accept        = rd_valid && rd_ready;
    assign mem_req_valid = can_issue &&
                           ((state == ST_FILL && n_iss < CNT_W'(WORDS)) ||
                            (state == ST_BYP  && n_iss == '0));
    assign mem_req_addr  = (state == ST_FILL) ? {cur_line, n_iss[WIDX_W-1:0], 2'b00}
                                              : {cur_addr[ADDR_W-1:2], 2'b00};
    assign issue         = mem_req_valid && mem_req_ready;
    assign wr_en         = (state == ST_FILL) && mem_rsp_valid;
    assign last_beat     = wr_en && (n_rx == CNT_W'(WORDS - 1));
    assign set_en        = last_beat && !killed && !inv_all && !inv_one;
    assign clr_en        = accept && cache_en && !lk_hit;
    assign unused_bits   = ^{rd_addr[1:0], idx_map};

    pte_cache_regs #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .hi_we(flush_hi_we), .hi_wdata(flush_hi_wdata),
        .flush_we(flush_we), .flush_wdata(flush_wdata),
        .cache_en(cache_en), .req_limit(req_limit), .idx_map(idx_map),
        .inv_all(inv_all), .inv_one(inv_one), .inv_line(inv_line)
    );

    pte_cache_store #(.LINES(LINES), .WORDS(WORDS), .LA_W(LA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_line(lk_line), .lk_word(rd_addr[OFS_W-1:2]),
        .lk_hit(lk_hit), .lk_data(lk_data),
        .wr_en(wr_en), .wr_idx(cur_idx), .wr_word(n_rx[WIDX_W-1:0]), .wr_data(mem_rsp_data),
        .clr_en(clr_en), .clr_idx(lk_idx),
        .set_en(set_en), .set_idx(cur_idx), .set_line(cur_line),
        .inv_all(inv_all), .inv_one(inv_one), .inv_line(inv_line),
        .line_vld(line_vld)
    );

    pte_cache_ostd u_ostd (
        .clk(clk), .rst_n(rst_n), .req_limit(req_limit),
        .issue(issue), .retire(mem_rsp_valid), .can_issue(can_issue)
    );

    // Sequence walker reads through hit, fill and bypass paths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            n_iss     <= '0;
            n_rx      <= '0;
            killed    <= 1'b0;
            pend_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (issue)
                n_iss <= n_iss + CNT_W'(1);
            case (state)
                ST_IDLE: if (accept) begin
                    cur_addr <= rd_addr;
                    n_iss    <= '0;
                    n_rx     <= '0;
                    killed   <= 1'b0;
                    if (cache_en && lk_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= lk_data;
                    end else if (cache_en) begin
                        state <= ST_FILL;
                    end else begin
                        state <= ST_BYP;
                    end
                end
                ST_FILL: begin
                    if (inv_all || inv_one)
                        killed <= 1'b1;
                    if (mem_rsp_valid) begin
                        n_rx <= n_rx + CNT_W'(1);
                        if (n_rx[WIDX_W-1:0] == cur_word)
                            pend_q <= mem_rsp_data;
                        if (last_beat) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= (cur_word == WIDX_W'(WORDS - 1)) ? mem_rsp_data : pend_q;
                            state     <= ST_IDLE;
                        end
                    end
                end
                ST_BYP: if (mem_rsp_valid) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= mem_rsp_data;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pte_cache_chk.sv
// Protocol checker for the page table entry cache, attached by bind.
// Assumes: memory answers each accepted read once, in order.
module pte_cache_chk #(
    parameter int LINES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic             rsp_valid,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_rsp_valid,
    input logic             flush_we,
    input logic             flush_type,
    input logic             cache_en,
    input logic             lk_hit,
    input logic [3:0]       req_limit,
    input logic [LINES-1:0] line_vld
);
    import pte_cache_pkg::*;

    logic [4:0] o_cnt;

    // Independent count of memory reads in flight
    always_ff @(posedge clk) begin
        if (!rst_n)
            o_cnt <= '0;
        else
            o_cnt <= o_cnt + 5'(mem_req_valid && mem_req_ready) - 5'(mem_rsp_valid);
    end

    // R9
    limit_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (o_cnt < eff_limit(req_limit)));

    // R3
    hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && cache_en && lk_hit) |=> rsp_valid);

    // R2
    miss_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && cache_en && !lk_hit) |=> !rsp_valid);

    // R5
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_we && !flush_type) |=> (line_vld == '0));

    // R12
    walker_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rd_ready);

    // R8
    bypass_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !cache_en) |=> !rsp_valid);

endmodule

bind pte_cache pte_cache_chk #(.LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .flush_we(flush_we), .flush_type(flush_wdata[0]),
    .cache_en(cache_en), .lk_hit(lk_hit), .req_limit(req_limit),
    .line_vld(line_vld)
);

// File: tb/pte_cache_tb.sv
module pte_cache_tb;
    localparam int CLK_NS = 10;
    localparam int ADDR_W = 34;
    localparam int LINES  = 8;
    localparam int LAT    = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_valid = 1'b0;
    logic              rd_ready;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_data;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              cfg_we = 1'b0;
    logic [31:0]       cfg_wdata = '0;
    logic              flush_hi_we = 1'b0;
    logic [1:0]        flush_hi_wdata = '0;
    logic              flush_we = 1'b0;
    logic [31:0]       flush_wdata = '0;

    always #(CLK_NS/2) clk = ~clk;
    assign mem_req_ready = 1'b1;

    pte_cache #(.ADDR_W(ADDR_W), .ATOM_BYTES(32), .LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .flush_hi_we(flush_hi_we), .flush_hi_wdata(flush_hi_wdata),
        .flush_we(flush_we), .flush_wdata(flush_wdata)
    );

    integer n_chk = 0, n_fail = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mem_fn(input logic [ADDR_W-1:0] a);
        return {a[31:2], a[33:32]} ^ 32'h3C5A_9600;
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: in-order, fixed latency, one answer per cycle
    logic [ADDR_W-1:0] q_addr[$];
    longint            q_due[$];
    logic [ADDR_W-1:0] req_log[$];
    integer n_req = 0, n_rsp = 0, max_out = 0;
    longint last_rsp_cyc = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_rsp_valid) begin
                n_rsp++;
                last_rsp_cyc = cyc;
            end
            if (mem_req_valid && mem_req_ready) begin
                q_addr.push_back(mem_req_addr);
                q_due.push_back(cyc + LAT);
                req_log.push_back(mem_req_addr);
                n_req++;
            end
            if (q_addr.size() > 0 && q_due[0] <= cyc) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_fn(q_addr[0]);
                void'(q_addr.pop_front());
                void'(q_due.pop_front());
            end else begin
                mem_rsp_valid <= 1'b0;
            end
        end
    end

    // Per-clock tracking of reads in flight
    always @(negedge clk) begin
        if (rst_n && (n_req - n_rsp) > max_out)
            max_out = n_req - n_rsp;
    end

    // Reference model of the line store and configuration
    bit          mv[LINES];
    logic [28:0] mt[LINES];
    bit          m_en = 1'b1;
    logic [5:0]  m_map = 6'h3f;
    bit          busy = 1'b0, fill_killed = 1'b0;

    function automatic int midx(input logic [28:0] line);
        return int'(line[2:0] & m_map[2:0]);
    endfunction

    task automatic cfg_write(input bit en, input logic [3:0] lim, input logic [5:0] map);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = 32'h0;
        cfg_wdata[29]    = en;
        cfg_wdata[27:24] = lim;
        cfg_wdata[5:0]   = map;
        @(negedge clk);
        cfg_we = 1'b0;
        m_en  = en;
        m_map = map;
    endtask

    task automatic flush_all();
        @(negedge clk);
        flush_we    = 1'b1;
        flush_wdata = 32'h0;
        @(negedge clk);
        flush_we = 1'b0;
        for (int i = 0; i < LINES; i++) mv[i] = 1'b0;
        if (busy) fill_killed = 1'b1;
    endtask

    task automatic flush_addr(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        flush_hi_we    = 1'b1;
        flush_hi_wdata = a[33:32];
        @(negedge clk);
        flush_hi_we = 1'b0;
        flush_we    = 1'b1;
        flush_wdata = a[31:0] | 32'h1;
        @(negedge clk);
        flush_we = 1'b0;
        for (int i = 0; i < LINES; i++)
            if (mt[i] == a[33:5]) mv[i] = 1'b0;
        if (busy) fill_killed = 1'b1;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
        logic [28:0] line;
        int          idx, n0;
        bit          hit, en0, seen;
        line = a[33:5];
        idx  = midx(line);
        while (!rd_ready) @(negedge clk);
        en0 = m_en;
        hit = m_en && mv[idx] && (mt[idx] == line);
        req_log.delete();
        n0 = n_req;
        if (!hit) begin
            busy = 1'b1;
            fill_killed = 1'b0;
            if (m_en) mv[idx] = 1'b0;
        end
        rd_valid = 1'b1;
        rd_addr  = a;
        @(negedge clk);
        rd_valid = 1'b0;
        if (hit) begin
            // R3: hit answers in the next cycle without memory traffic
            check_eq({req, " R3"}, "hit rsp_valid", 64'(rsp_valid), 64'd1);
            check_eq({req, " R3"}, "hit data", 64'(rsp_data), 64'(mem_fn({a[33:2], 2'b00})));
            check_eq({req, " R3"}, "hit mem reads", 64'(n_req - n0), 64'd0);
        end else begin
            // R12: walker is held off while memory is used
            check_eq({req, " R12"}, "rd_ready during miss", 64'(rd_ready), 64'd0);
            seen = 1'b0;
            for (int t = 0; t < 150 && !seen; t++) begin
                if (rsp_valid) seen = 1'b1;
                else @(negedge clk);
            end
            check_eq({req, " R2"}, "response seen", 64'(seen), 64'd1);
            check_eq({req, " R2"}, "response cycle", 64'(cyc), 64'(last_rsp_cyc + 1));
            check_eq({req, " R2"}, "miss data", 64'(rsp_data), 64'(mem_fn({a[33:2], 2'b00})));
            if (en0) begin
                check_eq({req, " R2"}, "fill read count", 64'(req_log.size()), 64'd8);
                if (req_log.size() == 8)
                    for (int i = 0; i < 8; i++)
                        check_eq({req, " R2"}, "fill address", 64'(req_log[i]),
                                 64'({line, 3'(i), 2'b00}));
                if (!fill_killed) begin
                    mv[idx] = 1'b1;
                    mt[idx] = line;
                end
            end else begin
                // R8: uncached read is a single word read
                check_eq({req, " R8"}, "bypass read count", 64'(req_log.size()), 64'd1);
                if (req_log.size() == 1)
                    check_eq({req, " R8"}, "bypass address", 64'(req_log[0]),
                             64'({a[33:2], 2'b00}));
            end
            busy = 1'b0;
        end
        @(negedge clk);
        check_eq(req, "single response pulse", 64'(rsp_valid), 64'd0);
    endtask

    task automatic expect_hit(input logic [ADDR_W-1:0] a, input bit exp, input string req);
        logic [28:0] line;
        line = a[33:5];
        check_eq(req, "model hit state", 64'(m_en && mv[midx(line)] && mt[midx(line)] == line),
                 64'(exp));
        do_read(a, req);
    endtask

    localparam logic [ADDR_W-1:0] A = 34'h0_0000_1044;
    localparam logic [ADDR_W-1:0] B = 34'h2_0000_1044;
    localparam logic [ADDR_W-1:0] C = 34'h0_0000_2068;
    localparam logic [ADDR_W-1:0] F = 34'h0_0000_5024;
    localparam logic [ADDR_W-1:0] G = 34'h0_0000_5048;

    initial begin
        for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; mt[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "rd_ready", 64'(rd_ready), 64'd1);
        check_eq("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        check_eq("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);

        // R1 R9: default cap 8 lets all eight fill reads go out together
        max_out = 0;
        expect_hit(A, 1'b0, "R2 first miss");
        check_eq("R1", "default cap reached", 64'(max_out), 64'd8);
        expect_hit(A + 34'h4,  1'b1, "R3 same line");
        expect_hit(A + 34'h18, 1'b1, "R3 last word");
        expect_hit(A - 34'h4,  1'b1, "R3 first word");

        // R4: upper bits separate lines with equal low bits
        expect_hit(B, 1'b0, "R4 upper alias");
        expect_hit(A, 1'b0, "R4 evicted");
        expect_hit(C, 1'b0, "R6 other line");

        // R7: flush address upper bits taken from the high register
        flush_addr(34'h2_0000_1050);
        expect_hit(A, 1'b1, "R7 wrong upper bits");
        // R6: unaligned address flush drops only its line
        flush_addr(34'h0_0000_105A);
        expect_hit(C, 1'b1, "R6 neighbour kept");
        expect_hit(A, 1'b0, "R6 flushed line");

        // R5: whole-cache flush
        flush_all();
        expect_hit(C, 1'b0, "R5 after flush all");
        expect_hit(A, 1'b0, "R5 after flush all");

        // R9: smaller cap, and zero meaning sixteen
        cfg_write(1'b1, 4'd3, 6'h3f);
        max_out = 0;
        do_read(34'h0_0000_3000, "R9 cap3");
        check_eq("R9", "max in flight cap 3", 64'(max_out), 64'd3);
        cfg_write(1'b1, 4'd0, 6'h3f);
        max_out = 0;
        do_read(34'h0_0000_4000, "R9 cap0");
        check_eq("R9", "max in flight cap 0", 64'(max_out), 64'd8);
        cfg_write(1'b1, 4'd8, 6'h3f);

        // R10: zero index mask forces collisions
        cfg_write(1'b1, 4'd8, 6'h00);
        expect_hit(F, 1'b0, "R10 mask0 F");
        expect_hit(G, 1'b0, "R10 mask0 G");
        expect_hit(F, 1'b0, "R10 mask0 conflict");
        cfg_write(1'b1, 4'd8, 6'h3f);
        do_read(F, "R10 mask full F");
        do_read(G, "R10 mask full G");
        expect_hit(F, 1'b1, "R10 coexist");

        // R8: disabled cache bypasses and does not allocate
        cfg_write(1'b0, 4'd8, 6'h3f);
        do_read(34'h0_0000_7010, "R8 bypass 1");
        do_read(34'h0_0000_7010, "R8 bypass 2");
        do_read(F, "R8 bypass cached line");
        cfg_write(1'b1, 4'd8, 6'h3f);
        expect_hit(34'h0_0000_7010, 1'b0, "R8 not allocated");
        expect_hit(F, 1'b1, "R8 lines kept");

        // R11: flush during a fill still answers but leaves line invalid
        fork
            do_read(34'h0_0000_6008, "R11 killed fill");
            begin
                repeat (4) @(negedge clk);
                flush_all();
            end
        join
        check_eq("R11", "fill marked killed", 64'(fill_killed), 64'd1);
        expect_hit(34'h0_0000_6008, 1'b0, "R11 refetch");
        expect_hit(34'h0_0000_600C, 1'b1, "R11 refilled");

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule